// File: doc/BRIEF.md
# Display Driver Power-Up and Identity Probe Sequencer

This block brings an external display driver IC out of power-on and confirms that the expected part is present before any panel setup starts. On a start pulse it steps two active-low board pins, a write-protect line and a reset line, through a fixed order of edges with timed gaps between them. It then runs a short exchange over a parallel system bus that has a register-select line. It clears access protection, takes the driver out of deep standby, issues the identity command, waits, and reads the identity back.

The bus side is a request/acknowledge strobe to a separate bus engine, one transfer per accepted request. The four identity bytes are packed into a 32-bit word and compared with a fixed code. The block ends with `done` and exactly one of `pass` or `fail`, and holds them until the next start. All waits are cycle counts derived from the `CLK_HZ` parameter and rounded up, with a minimum of one cycle.

Top module: `panel_probe_seq`

## Requirements
- R1: After reset, `pin_protect_n` and `pin_reset_n` are high, and `bus_req`, `done`, `pass` and `fail` are low.
- R2: A start accepted in idle or done drives `pin_protect_n` low on that clock edge. `pin_reset_n` falls one cycle later, and `pin_protect_n` rises one cycle after that.
- R3: `pin_reset_n` rises exactly T_HOLD cycles after `pin_protect_n` rises, where T_HOLD = ceil(CLK_HZ x 1.1 ms), minimum 1.
- R4: `pin_protect_n` falls again exactly T_SETTLE = ceil(CLK_HZ x 10 us) cycles after `pin_reset_n` rises.
- R5: The first `bus_req` rises exactly T_BOOT = ceil(CLK_HZ x 20 ms) cycles after that second protect fall. There is never a request while `pin_reset_n` is low.
- R6: A transfer completes in each cycle where `bus_req` and `bus_ack` are both high. While `bus_req` is high and not yet acknowledged, `bus_req`, `bus_rd`, `bus_rs` and `bus_wdata` stay stable.
- R7: The first five transfers are writes (`bus_rd`=0) in this order, given as (bus_rs, value): (0,0xB0), (1,0x00), (0,0xB1), (1,0x00), (0,0xBF). `bus_rs`=0 marks a command cycle carrying 8 bits in `bus_wdata[7:0]`, with `bus_wdata[17:8]` zero.
- R8: After the 0xBF command is accepted, `bus_req` stays low for exactly T_ID = ceil(CLK_HZ x 50 ms) cycles before the reads start.
- R9: Five read transfers follow, each with `bus_rd`=1 and `bus_rs`=1. The first read is discarded. The next four supply bits [7:0] only, most significant byte first. `bus_rdata[17:8]` is ignored.
- R10: One cycle after the last read is accepted, `done` rises with `pass`=1 if the packed word equals 0x01221517 and with `fail`=1 otherwise, never both. No transfer follows.
- R11: `done`, `pass` and `fail` hold until a new start, which clears them. A start while the sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins the probe |
| pin_protect_n | output | 1 | Active-low write-protect pin to the driver board |
| pin_reset_n | output | 1 | Active-low reset pin to the driver IC |
| bus_req | output | 1 | Transfer request to the bus engine |
| bus_rd | output | 1 | 1 = read transfer, 0 = write transfer |
| bus_rs | output | 1 | Register select: 0 = command, 1 = parameter/data |
| bus_wdata | output | DATA_W (18) | Write value; commands use bits [7:0] |
| bus_ack | input | 1 | Bus engine accepts the current transfer |
| bus_rdata | input | DATA_W (18) | Read value, sampled when `bus_ack` is high |
| done | output | 1 | Probe finished |
| pass | output | 1 | Identity matched |
| fail | output | 1 | Identity mismatched (no device) |

## Verification
Two cases are the hardest to reach from the ports. One is a start pulse that arrives in the middle of the power-up waits. The other is a read path that must ignore both the dummy byte and the upper bits of each read. The bench's bus responder returns chosen values on each read. It fills the dummy slot and bits [17:8] with junk and still expects a pass. It also feeds a byte-reversed identity and expects a fail. A second start is injected during the 20 ms boot wait, and the bench then counts the reset-pin edges to show the sequence did not restart.

// File: rtl/panel_probe_pkg.sv
// Shared types and helpers for the panel probe sequencer.
// Assumes callers pass frequencies in Hz and durations in microseconds.
package panel_probe_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RST_LO, ST_PROT_HI, ST_HOLD, ST_SETTLE, ST_BOOT,
        ST_WRITE, ST_ID_WAIT, ST_READ, ST_CHECK, ST_DONE
    } probe_state_e;

    localparam int UNLOCK_LEN = 5;

    // Cycles covering a duration, rounded up, never below one.
    function automatic longint unsigned us_to_cycles(longint unsigned hz, longint unsigned us);
        longint unsigned c;
        c = (hz * us + 64'd999_999) / 64'd1_000_000;
        return (c == 0) ? 64'd1 : c;
    endfunction

    // Unlock write list: {select, byte}; select 0 = command.
    function automatic logic [8:0] unlock_step(logic [2:0] idx);
        case (idx)
            3'd0:    return {1'b0, 8'hB0};
            3'd1:    return {1'b1, 8'h00};
            3'd2:    return {1'b0, 8'hB1};
            3'd3:    return {1'b1, 8'h00};
            default: return {1'b0, 8'hBF};
        endcase
    endfunction

endpackage

// File: rtl/probe_wait_timer.sv
// Loadable down-counter for sequencer waits.
// A load of N makes 'expired' pulse in the Nth cycle after the load edge.
// Assumes N >= 1; a load wins over counting.
module probe_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Count down to zero after each load.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == CNT_W'(1));
endmodule

// File: rtl/probe_id_packer.sv
// Packs successive bytes into a word, most significant byte first.
// Assumes the caller only asserts 'take' for bytes to keep.
module probe_id_packer #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic [BYTE_W-1:0] in_byte,
    output logic [WORD_W-1:0] word
);
    // Shift left by one byte on each kept read.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) word <= '0;
        else if (take)     word <= {word[WORD_W-BYTE_W-1:0], in_byte};
    end
endmodule

// File: rtl/panel_probe_seq.sv
// Power-up pin sequencer plus identity probe for a display driver IC.
// Drives the protect/reset pins with timed gaps, writes the unlock commands,
// reads the identity, and compares it with ID_CODE.
// Assumes the bus engine acknowledges each request eventually.
module panel_probe_seq
    import panel_probe_pkg::*;
#(
    parameter longint unsigned CLK_HZ  = 50_000_000,
    parameter int              DATA_W  = 18,
    parameter logic [31:0]     ID_CODE = 32'h0122_1517
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              pin_protect_n,
    output logic              pin_reset_n,
    output logic              bus_req,
    output logic              bus_rd,
    output logic              bus_rs,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic              pass,
    output logic              fail
);
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 32;
    localparam int ID_BYTES = WORD_W / BYTE_W;
    localparam int READ_LEN = ID_BYTES + 1;
    localparam longint unsigned T_HOLD   = us_to_cycles(CLK_HZ, 1100);
    localparam longint unsigned T_SETTLE = us_to_cycles(CLK_HZ, 10);
    localparam longint unsigned T_BOOT   = us_to_cycles(CLK_HZ, 20_000);
    localparam longint unsigned T_ID     = us_to_cycles(CLK_HZ, 50_000);
    localparam longint unsigned T_MAX    = (T_ID > T_BOOT) ? T_ID : T_BOOT;
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam logic [2:0] LAST_W = 3'(UNLOCK_LEN - 1);
    localparam logic [2:0] LAST_R = 3'(READ_LEN - 1);

    probe_state_e      state;
    logic [2:0]        step;
    logic              prot_q, rst_q, done_q, pass_q, fail_q;
    logic              tmr_load, tmr_exp;
    logic [CNT_W-1:0]  tmr_val;
    logic [WORD_W-1:0] id_word;
    logic [8:0]        wr_item;
    logic              go;
    logic              unused_rdata_hi;

    assign go              = start && (state == ST_IDLE || state == ST_DONE);
    assign wr_item         = unlock_step(step);
    assign unused_rdata_hi = ^bus_rdata[DATA_W-1:BYTE_W];

    // Pick the wait length to arm when entering a timed state.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (1'b1)
            state == ST_PROT_HI:                          begin tmr_load = 1'b1; tmr_val = CNT_W'(T_HOLD);   end
            state == ST_HOLD && tmr_exp:                  begin tmr_load = 1'b1; tmr_val = CNT_W'(T_SETTLE); end
            state == ST_SETTLE && tmr_exp:                begin tmr_load = 1'b1; tmr_val = CNT_W'(T_BOOT);   end
            state == ST_WRITE && bus_ack && step == LAST_W: begin tmr_load = 1'b1; tmr_val = CNT_W'(T_ID);   end
            default: ;
        endcase
    end

    probe_wait_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    probe_id_packer #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) packer_i (
        .clk(clk), .rst_n(rst_n), .clr(go),
        .take(state == ST_READ && bus_ack && step != 3'd0),
        .in_byte(bus_rdata[BYTE_W-1:0]), .word(id_word)
    );

    // Main sequence: pin ritual, unlock writes, identity read, verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            step   <= '0;
            prot_q <= 1'b1;
            rst_q  <= 1'b1;
            done_q <= 1'b0;
            pass_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: if (start) begin
                    prot_q <= 1'b0;
                    done_q <= 1'b0;
                    pass_q <= 1'b0;
                    fail_q <= 1'b0;
                    state  <= ST_RST_LO;
                end
                ST_RST_LO:  begin rst_q  <= 1'b0; state <= ST_PROT_HI; end
                ST_PROT_HI: begin prot_q <= 1'b1; state <= ST_HOLD;    end
                ST_HOLD:    if (tmr_exp) begin rst_q  <= 1'b1; state <= ST_SETTLE; end
                ST_SETTLE:  if (tmr_exp) begin prot_q <= 1'b0; state <= ST_BOOT;   end
                ST_BOOT:    if (tmr_exp) begin step <= '0; state <= ST_WRITE;     end
                ST_WRITE: if (bus_ack) begin
                    if (step == LAST_W) state <= ST_ID_WAIT;
                    else                step  <= step + 1'b1;
                end
                ST_ID_WAIT: if (tmr_exp) begin step <= '0; state <= ST_READ; end
                ST_READ: if (bus_ack) begin
                    if (step == LAST_R) state <= ST_CHECK;
                    else                step  <= step + 1'b1;
                end
                ST_CHECK: begin
                    done_q <= 1'b1;
                    pass_q <= (id_word == ID_CODE);
                    fail_q <= (id_word != ID_CODE);
                    state  <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign pin_protect_n = prot_q;
    assign pin_reset_n   = rst_q;
    assign bus_req       = (state == ST_WRITE) || (state == ST_READ);
    assign bus_rd        = (state == ST_READ);
    assign bus_rs        = (state == ST_READ) ? 1'b1 : wr_item[8];
    assign bus_wdata     = (state == ST_WRITE) ? DATA_W'(wr_item[7:0]) : '0;
    assign done          = done_q;
    assign pass          = pass_q;
    assign fail          = fail_q;
endmodule

// File: rtl/panel_probe_seq_chk.sv
// Protocol checker for panel_probe_seq, attached by bind below.
// Assumes synchronous active-low reset; all properties are off during reset.
module panel_probe_seq_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              pin_protect_n,
    input logic              pin_reset_n,
    input logic              bus_req,
    input logic              bus_rd,
    input logic              bus_rs,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack,
    input logic              done,
    input logic              pass,
    input logic              fail
);
    // Reset pin only falls while protect is already low.
    assert_reset_under_protect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_reset_n) |-> !pin_protect_n);

    // No bus traffic while the driver is held in reset.
    assert_no_req_in_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_reset_n |-> !bus_req);

    // Pending request holds its fields until acknowledged.
    assert_req_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_rd) && $stable(bus_rs) && $stable(bus_wdata));

    // Command cycles carry only 8 bits.
    assert_cmd_narrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_rs |-> bus_wdata[DATA_W-1:8] == '0);

    // Reads are data-select cycles.
    assert_read_is_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_rd |-> bus_rs);

    // Exactly one verdict once done, and the bus is quiet.
    assert_one_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass ^ fail) && !bus_req);

    // Verdict is held until a new start.
    assert_verdict_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(pass) && $stable(fail));
endmodule

bind panel_probe_seq panel_probe_seq_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/panel_probe_seq_tb_top.sv
// Directed bench for panel_probe_seq with a scripted bus responder.
module panel_probe_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam longint unsigned HZ = 20_000;
    localparam int DW = 18;
    // Expected waits: ceil(HZ * duration), at least one cycle.
    localparam int E_HOLD   = int'((HZ * 1100 + 999_999) / 1_000_000);
    localparam int E_SETTLE = ((HZ * 10 + 999_999) / 1_000_000) == 0 ? 1 : int'((HZ * 10 + 999_999) / 1_000_000);
    localparam int E_BOOT   = int'((HZ * 20_000 + 999_999) / 1_000_000);
    localparam int E_ID     = int'((HZ * 50_000 + 999_999) / 1_000_000);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic pin_protect_n, pin_reset_n, bus_req, bus_rd, bus_rs, done, pass, fail;
    logic [DW-1:0] bus_wdata;

    int checks = 0, errors = 0;
    int cyc = 0;
    int n_evt = 0, evt_kind[32], evt_t[32];
    int n_rise = 0, rise_t[8], n_fall = 0, fall_t[8];
    int n_xf = 0, xf_rd[32], xf_rs[32], xf_data[32];
    int stab_err = 0, ack_delay = 0, rd_idx = 0;
    logic [DW-1:0] rd_vals[5];

    always #(CLK_PERIOD/2) clk = ~clk;

    panel_probe_seq #(.CLK_HZ(HZ), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pin_protect_n(pin_protect_n), .pin_reset_n(pin_reset_n),
        .bus_req(bus_req), .bus_rd(bus_rd), .bus_rs(bus_rs), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .done(done), .pass(pass), .fail(fail)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Pin and request edge monitor, sampled at the falling edge.
    initial begin
        logic pp, pr, pq;
        pp = 1'b1; pr = 1'b1; pq = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (n_evt < 32) begin
                if (pp && !pin_protect_n) begin evt_kind[n_evt] = 1; evt_t[n_evt] = cyc; n_evt++; end
                else if (!pp && pin_protect_n) begin evt_kind[n_evt] = 2; evt_t[n_evt] = cyc; n_evt++; end
                if (pr && !pin_reset_n) begin evt_kind[n_evt] = 3; evt_t[n_evt] = cyc; n_evt++; end
                else if (!pr && pin_reset_n) begin evt_kind[n_evt] = 4; evt_t[n_evt] = cyc; n_evt++; end
            end
            if (!pq && bus_req && n_rise < 8) begin rise_t[n_rise] = cyc; n_rise++; end
            if (pq && !bus_req && n_fall < 8) begin fall_t[n_fall] = cyc; n_fall++; end
            pp = pin_protect_n; pr = pin_reset_n; pq = bus_req;
        end
    end

    // Bus engine model: acknowledges after ack_delay waits, logs transfers.
    initial begin
        int wcnt;
        logic s_rd, s_rs;
        logic [DW-1:0] s_wd;
        wcnt = 0; s_rd = 0; s_rs = 0; s_wd = '0;
        forever begin
            @(negedge clk);
            if (bus_req) begin
                if (wcnt == 0) begin s_rd = bus_rd; s_rs = bus_rs; s_wd = bus_wdata; end
                else if (s_rd != bus_rd || s_rs != bus_rs || s_wd != bus_wdata) stab_err++;
                if (wcnt >= ack_delay) begin
                    bus_ack = 1'b1;
                    if (n_xf < 32) begin
                        xf_rd[n_xf] = int'(bus_rd); xf_rs[n_xf] = int'(bus_rs); xf_data[n_xf] = int'(bus_wdata);
                        n_xf++;
                    end
                    if (bus_rd) begin
                        bus_rdata = (rd_idx < 5) ? rd_vals[rd_idx] : '0;
                        rd_idx++;
                    end
                    wcnt = 0;
                end else begin
                    bus_ack = 1'b0;
                    wcnt++;
                end
            end else begin
                bus_ack = 1'b0;
                wcnt = 0;
            end
        end
    end

    task automatic clear_logs();
        n_evt = 0; n_rise = 0; n_fall = 0; n_xf = 0; stab_err = 0; rd_idx = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n;
        n = 0;
        while (!done && n < 6000) begin @(negedge clk); n++; end
        check(done == 1'b1, {tag, " done reached"}, int'(done), 1);
    endtask

    // R1: reset state at the ports.
    task automatic test_reset();
        check(pin_protect_n == 1'b1, "R1 protect idle", int'(pin_protect_n), 1);
        check(pin_reset_n == 1'b1, "R1 reset idle", int'(pin_reset_n), 1);
        check({bus_req, done, pass, fail} == 4'b0, "R1 outputs low", int'({bus_req, done, pass, fail}), 0);
    endtask

    // Full probe with a correct identity and a slow bus engine.
    task automatic test_good_probe();
        int exp_rs[5], exp_d[5];
        exp_rs = '{0, 1, 0, 1, 0};
        exp_d  = '{'hB0, 'h00, 'hB1, 'h00, 'hBF};
        clear_logs();
        ack_delay = 2;
        rd_vals = '{18'h00, 18'h01, 18'h22, 18'h15, 18'h17};
        pulse_start();
        wait_done("R10 good");
        check(n_evt == 5 && evt_kind[0] == 1 && evt_kind[1] == 3 && evt_kind[2] == 2 && evt_kind[3] == 4 && evt_kind[4] == 1,
              "R2 pin edge order", n_evt, 5);
        check(evt_t[1] - evt_t[0] == 1 && evt_t[2] - evt_t[1] == 1, "R2 edge spacing", evt_t[2] - evt_t[0], 2);
        check(evt_t[3] - evt_t[2] == E_HOLD, "R3 hold wait", evt_t[3] - evt_t[2], E_HOLD);
        check(evt_t[4] - evt_t[3] == E_SETTLE, "R4 settle wait", evt_t[4] - evt_t[3], E_SETTLE);
        check(rise_t[0] - evt_t[4] == E_BOOT, "R5 boot wait", rise_t[0] - evt_t[4], E_BOOT);
        check(stab_err == 0, "R6 request stability", stab_err, 0);
        check(n_xf == 10, "R6 transfer count", n_xf, 10);
        for (int i = 0; i < 5; i++)
            check(xf_rd[i] == 0 && xf_rs[i] == exp_rs[i] && xf_data[i] == exp_d[i], "R7 unlock write",
                  (xf_rs[i] << 8) | xf_data[i], (exp_rs[i] << 8) | exp_d[i]);
        check(n_rise == 2 && n_fall >= 1 && rise_t[1] - fall_t[0] == E_ID, "R8 identity wait",
              rise_t[1] - fall_t[0], E_ID);
        for (int i = 5; i < 10; i++)
            check(xf_rd[i] == 1 && xf_rs[i] == 1, "R9 read cycle", (xf_rd[i] << 1) | xf_rs[i], 3);
        check(pass == 1'b1 && fail == 1'b0, "R10 pass verdict", int'({pass, fail}), 2);
        repeat (20) @(negedge clk);
        check(n_xf == 10 && !bus_req, "R10 bus quiet after done", n_xf, 10);
        check(done && pass, "R11 verdict held", int'({done, pass}), 3);
    endtask

    // Dummy and upper bits carry junk; the identity must still match.
    task automatic test_junk_bits();
        clear_logs();
        ack_delay = 0;
        rd_vals = '{18'h3FFEE, 18'h2AB01, 18'h15522, 18'h3FF15, 18'h10017};
        pulse_start();
        wait_done("R9 junk");
        check(pass == 1'b1 && fail == 1'b0, "R9 dummy and high bits ignored", int'({pass, fail}), 2);
    endtask

    // Wrong identity and reversed byte order both fail.
    task automatic test_bad_ids();
        clear_logs();
        ack_delay = 1;
        rd_vals = '{18'h00, 18'h01, 18'h22, 18'h15, 18'h18};
        pulse_start();
        wait_done("R10 bad");
        check(fail == 1'b1 && pass == 1'b0, "R10 mismatch fails", int'({pass, fail}), 1);
        clear_logs();
        rd_vals = '{18'h00, 18'h17, 18'h15, 18'h22, 18'h01};
        pulse_start();
        @(negedge clk);
        check(done == 1'b0 && fail == 1'b0, "R11 start clears verdict", int'({done, fail}), 0);
        wait_done("R9 order");
        check(fail == 1'b1, "R9 most significant byte first", int'(fail), 1);
    endtask

    // Start pulse during the boot wait must not restart the ritual.
    task automatic test_mid_start();
        clear_logs();
        ack_delay = 0;
        rd_vals = '{18'h00, 18'h01, 18'h22, 18'h15, 18'h17};
        pulse_start();
        repeat (E_HOLD + 40) @(negedge clk);
        pulse_start();
        wait_done("R11 mid");
        begin
            int nrf;
            nrf = 0;
            for (int i = 0; i < n_evt; i++) if (evt_kind[i] == 3) nrf++;
            check(nrf == 1, "R11 start while busy ignored", nrf, 1);
        end
        check(pass == 1'b1 && n_xf == 10, "R11 run completes normally", n_xf, 10);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (200_000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_good_probe();
        test_junk_bits();
        test_bad_ids();
        test_mid_start();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule